// File: doc/BRIEF.md
# Page Program Byte Collector

This block gathers the data bytes of a single page-program command into a local page-sized buffer. At the start of a command it receives a start address. The upper address bits select the page. The lower bits give the first in-page offset. Each data strobe that follows stores one byte at the current offset and then advances it. The offset wraps inside the page, so a stream longer than one page keeps only its final page worth of bytes. A bitmap records which offsets have been loaded.

When chip enable goes inactive, the surrounding command logic sends a one-cycle commit request. If at least one byte was loaded, the block writes every loaded byte to a byte-wide memory, one byte per cycle, in ascending offset order. Programming can only clear bits, so each stored value is the old memory byte ANDed with the buffered byte. Offsets that were not loaded are never written. After the last write the block raises a one-cycle completion pulse and a one-cycle pulse that clears the write-enable latch. A busy flag covers the whole commit, and any command or data input that arrives while busy is ignored.

Top module: `pageProgBuf`

## Requirements
- R1: After `cmdStart` with address A, the k-th `dataValid` byte (k counting from 0) is committed to page A[ADDR_W-1:8] at offset (A[7:0] + k) mod 256.
- R2: A stream that starts at a nonzero offset and runs past offset 255 continues at offset 0 of the same page and never touches a neighbouring page.
- R3: When more than 256 bytes are sent, each offset holds the last byte sent to it, so only the final 256 bytes are programmed.
- R4: Memory bytes at offsets that were not loaded, and all bytes outside the addressed page, keep their previous contents.
- R5: A commit starts only after a `csRise` pulse. `busy` is 1 from the cycle after `csRise` through the cycle in which `done` is 1, and 0 afterwards.
- R6: Each committed memory byte becomes old value AND buffered value.
- R7: `done` and `welClr` are single-cycle pulses, high together in the cycle right after the last memory write, and never high during a write.
- R8: During a commit, exactly one loaded byte is written per cycle, at strictly ascending offsets. The number of write cycles equals the number of distinct offsets loaded.
- R9: A `csRise` with no byte loaded since the last `cmdStart` starts no commit: `busy`, `done` and `welClr` all stay 0.
- R10: Each `cmdStart` forgets all previously loaded bytes, so bytes from an earlier command are not written again.
- R11: `cmdStart` and `dataValid` pulses seen while `busy` is 1 have no effect on the page contents or the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdStart | input | 1 | One-cycle pulse marking a new command; samples `startAddr` |
| startAddr | input | ADDR_W | Program start address (page and offset) |
| dataValid | input | 1 | One-cycle strobe: `dataByte` holds a data byte |
| dataByte | input | 8 | Data byte to buffer |
| csRise | input | 1 | Chip enable went inactive; requests the commit |
| memRdData | input | 8 | Current memory contents at `memAddr` (combinational read) |
| memAddr | output | ADDR_W | Memory address for the read and the write |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | 8 | Byte to write (old AND new) |
| busy | output | 1 | Commit in progress |
| done | output | 1 | One-cycle commit-complete pulse |
| welClr | output | 1 | One-cycle write-enable-latch clear pulse |

## Verification
The main function is tried with short streams at page offset zero, a full page, streams that cross offset 255 from a nonzero start, overruns of 300 and 512 bytes, and an empty command. These cases separate correct modular offset arithmetic from a design that spills into the next page or keeps the earliest bytes instead of the latest. Random commands with random start offsets and lengths run over randomly filled memory. In that memory some bytes are already partially cleared, so a plain write and a bit-clearing AND give different results. Injected commands and data during a commit show whether the busy gating protects the loaded map.

// File: rtl/pbPkg.sv
package pbPkg;
  typedef struct packed {
    logic loadStart;
    logic loadByte;
    logic commitWrite;
  } pbStrobes_t;
endpackage

// File: rtl/pbCtrl.sv
module pbCtrl
  import pbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic       dataValid,
  input  logic       csRise,
  input  logic       anyValid,
  output pbStrobes_t strb,
  output logic       busy,
  output logic       done,
  output logic       welClr
);
  typedef enum logic {S_IDLE, S_COMMIT} ctrlState_t;
  ctrlState_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE:   if (csRise && anyValid) stateNext = S_COMMIT;
      S_COMMIT: if (!anyValid) stateNext = S_IDLE;
      default:  stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb.loadStart   = (state == S_IDLE) && cmdStart;
    strb.loadByte    = (state == S_IDLE) && dataValid && !cmdStart;
    strb.commitWrite = (state == S_COMMIT) && anyValid;
    busy   = (state == S_COMMIT);
    done   = (state == S_COMMIT) && !anyValid;
    welClr = done;
  end

  // R5: a commit only begins after a chip-enable rise
  p_commit_after_cs_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(csRise));
  // R9: empty command yields no commit
  p_no_empty_commit_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && csRise && !anyValid) |=> !busy);
  // R7: completion is a single pulse
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R7: busy ends right after done
  p_busy_ends_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done));
endmodule

// File: rtl/pbData.sv
module pbData
  import pbPkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int PAGE_BYTES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  pbStrobes_t        strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [7:0]        dataByte,
  input  logic [7:0]        memRdData,
  output logic              anyValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - OFF_W;

  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validMap;
  logic [OFF_W-1:0]      wrPtr;
  logic [BASE_W-1:0]     pageBase;
  logic [OFF_W-1:0]      nextIdx;

  // lowest loaded offset
  always_comb begin
    nextIdx = '0;
    for (int i = PAGE_BYTES - 1; i >= 0; i--)
      if (validMap[i]) nextIdx = OFF_W'(i);
  end

  assign anyValid  = |validMap;
  assign memAddr   = {pageBase, nextIdx};
  assign memWrData = pageBuf[nextIdx] & memRdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validMap <= '0;
      wrPtr    <= '0;
      pageBase <= '0;
    end else if (strb.loadStart) begin
      validMap <= '0;
      wrPtr    <= startAddr[OFF_W-1:0];
      pageBase <= startAddr[ADDR_W-1:OFF_W];
    end else if (strb.loadByte) begin
      validMap[wrPtr] <= 1'b1;
      wrPtr           <= wrPtr + 1'b1;
    end else if (strb.commitWrite) begin
      validMap[nextIdx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.loadByte) pageBuf[wrPtr] <= dataByte;
  end

  // R10: a new command starts with an empty map
  p_clear_on_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadStart |=> (validMap == '0));
  // R8: offsets written in strictly ascending order
  p_ascending_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitWrite && $past(strb.commitWrite)) |-> (nextIdx > $past(nextIdx)));
  // R8: each written offset is retired
  p_write_retires_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitWrite |=> !validMap[$past(nextIdx)]);
endmodule

// File: rtl/pageProgBuf.sv
module pageProgBuf
  import pbPkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int PAGE_BYTES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              dataValid,
  input  logic [7:0]        dataByte,
  input  logic              csRise,
  input  logic [7:0]        memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [7:0]        memWrData,
  output logic              busy,
  output logic              done,
  output logic              welClr
);
  pbStrobes_t strb;
  logic       anyValid;

  pbCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .dataValid(dataValid),
    .csRise(csRise), .anyValid(anyValid), .strb(strb),
    .busy(busy), .done(done), .welClr(welClr)
  );

  pbData #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .startAddr(startAddr),
    .dataByte(dataByte), .memRdData(memRdData), .anyValid(anyValid),
    .memAddr(memAddr), .memWrData(memWrData)
  );

  assign memWrEn = strb.commitWrite;

  // R7: no completion pulse during a write
  p_done_not_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> !done);
  // R5: writes only while busy
  p_write_while_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> busy);
endmodule

// File: tb/test_pageProgBuf.sv
module test_pageProgBuf;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int MEM_SZ = 1 << AW;

  logic clk = 0, rstN = 0;
  logic cmdStart = 0, dataValid = 0, csRise = 0;
  logic [AW-1:0] startAddr = '0;
  logic [7:0] dataByte = '0;
  logic [7:0] memRdData;
  logic [AW-1:0] memAddr;
  logic memWrEn, busy, done, welClr;
  logic [7:0] memWrData;

  logic [7:0] mem [MEM_SZ];
  logic [7:0] expMem [MEM_SZ];
  int errors = 0, checks = 0;
  int wrCount = 0, orderErr = 0, timingErr = 0, lastOff = -1;
  logic prevWr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pageProgBuf #(.ADDR_W(AW)) i_pageProgBuf (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .startAddr(startAddr),
    .dataValid(dataValid), .dataByte(dataByte), .csRise(csRise),
    .memRdData(memRdData), .memAddr(memAddr), .memWrEn(memWrEn),
    .memWrData(memWrData), .busy(busy), .done(done), .welClr(welClr)
  );

  assign memRdData = mem[memAddr];

  always @(posedge clk) begin
    if (memWrEn) begin
      mem[memAddr] <= memWrData;
      wrCount <= wrCount + 1;
      if (int'(memAddr[7:0]) <= lastOff) orderErr <= orderErr + 1;
      lastOff <= int'(memAddr[7:0]);
      if (done) timingErr <= timingErr + 1;
    end
    if (done && !prevWr) timingErr <= timingErr + 1;
    prevWr <= memWrEn;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int memDiffs();
    int d = 0;
    for (int i = 0; i < MEM_SZ; i++) if (mem[i] !== expMem[i]) d++;
    return d;
  endfunction

  // one command: n bytes starting at addr; inject = stimulus during busy (R11)
  task automatic runCmd(input int addr, input int n, input bit inject, input string req);
    logic [7:0] shadow [256];
    bit loaded [256];
    int nLoaded = 0, busyCycles = 0, guard = 0;
    for (int i = 0; i < 256; i++) loaded[i] = 0;
    wrCount = 0; orderErr = 0; timingErr = 0; lastOff = -1;
    @(negedge clk);
    cmdStart = 1; startAddr = AW'(addr);
    @(negedge clk);
    cmdStart = 0;
    for (int k = 0; k < n; k++) begin
      logic [7:0] b = 8'($urandom);
      int off = ((addr & 255) + k) % 256;
      dataValid = 1; dataByte = b;
      shadow[off] = b; loaded[off] = 1;
      @(negedge clk);
    end
    dataValid = 0;
    for (int i = 0; i < 256; i++) if (loaded[i]) begin
      nLoaded++;
      expMem[(addr & ~255) + i] = expMem[(addr & ~255) + i] & shadow[i];
    end
    csRise = 1;
    @(negedge clk);
    csRise = 0;
    if (nLoaded == 0) begin
      check(!busy && !done && !welClr, "R9 empty command idle", int'(busy), 0);
      repeat (3) @(negedge clk);
      check(!busy && !welClr, "R9 no late commit", int'(busy), 0);
    end else begin
      check(busy, "R5 busy after csRise", int'(busy), 1);
      while (!done && guard < 2000) begin
        busyCycles++; guard++;
        if (inject && busyCycles == 2) begin
          cmdStart = 1; startAddr = AW'(addr ^ 12'h300); dataValid = 1; dataByte = 8'h00;
        end else begin
          cmdStart = 0; dataValid = 0;
        end
        @(negedge clk);
      end
      cmdStart = 0; dataValid = 0;
      check(done && welClr && busy, "R7 done with welClr", int'(welClr), 1);
      check(busyCycles == nLoaded, "R8 one write per cycle", busyCycles, nLoaded);
      @(negedge clk);
      check(!busy && !done && !welClr, "R5 busy clears after done", int'(busy), 0);
    end
    check(wrCount == nLoaded, "R8 write count", wrCount, nLoaded);
    check(orderErr == 0, "R8 ascending order", orderErr, 0);
    check(timingErr == 0, "R7 done timing", timingErr, 0);
    check(memDiffs() == 0, req, memDiffs(), 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < MEM_SZ; i++) begin
      mem[i] = (i % 3 == 0) ? 8'hFF : 8'($urandom);
      expMem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check(!busy && !done && !welClr && !memWrEn, "R5 reset state", int'(busy), 0);
    rstN = 1;
    @(negedge clk);
    runCmd(12'h100, 1, 0, "R1 single byte at offset 0");
    runCmd(12'h200, 256, 0, "R1 R6 full page");
    runCmd(12'h3F0, 40, 0, "R2 wrap within page");
    runCmd(12'h405, 300, 0, "R3 overrun 300 bytes");
    runCmd(12'h500, 512, 0, "R3 overrun 512 bytes");
    runCmd(12'h610, 0, 0, "R9 no bytes");
    runCmd(12'h720, 5, 0, "R4 sparse load keeps others");
    runCmd(12'h720, 3, 0, "R10 second command forgets first");
    runCmd(12'h830, 20, 1, "R11 inputs ignored while busy");
    for (int t = 0; t < 20; t++)
      runCmd(int'($urandom % MEM_SZ), int'($urandom % 300), t % 4 == 0,
             "R1 R4 R6 random command");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule